// File: doc/BRIEF.md
# Channel-Gain Scan Sequencer

This block sits in front of a multiplexed A/D converter. It stores a short programmable list of (channel, gain) pairs and presents the selected pair on its channel-select and gain-select outputs. Each completed conversion moves it to the next list entry, and after the last entry it returns to the first. Software reaches it through a small word-wide register port. That port has four registers: a list-control register, an A/D control/status register, a supervisor command register and a read-only result register.

The host first opens the list for loading by setting the load-enable bit in the list-control register. Each A/D control write then appends one entry. The list length is written as the entry count minus one. A preload command points the sequencer at entry 0 and starts a settling interval, and the busy flag stays up for that whole interval. Conversion triggers are honoured only after settling has finished. A trigger comes either from a software command or from a pacer tick that is gated by a clock-enable bit. The block pulses `conv_start` toward the converter and latches the result when `conv_done` returns. It then raises a done flag, which is cleared by reading the result. A trigger that is accepted while an earlier result is still unread raises a sticky overrun error.

Top module: `cg_scan_seq`

## Requirements
- R1: After reset, `chan_sel`, `gain_sel`, `done_flag`, `err_flag` and `conv_start` are 0, and the status register (address 0) reads 0x0000.
- R2: Writing the list-control register (address 1) with bit 15 set opens load mode and restarts the write slot at entry 0. In load mode each write to address 0 stores channel = bits 3:0 and gain = bits 5:4 into the next entry. Bits 3:0 of the list-control register hold the entry count minus one and read back at address 1.
- R3: A supervisor write (address 3) with bit 4 set selects entry 0 and raises the busy flag (status bit 8) for exactly SETTLE_CYC cycles.
- R4: A trigger is ignored while busy is set, and also before the first preload that follows an init. An ignored trigger produces no `conv_start`.
- R5: A supervisor write with bit 3 set, once settling has finished, makes `conv_start` high for exactly one cycle. That cycle is the one right after the write.
- R6: `conv_done` during a conversion latches `conv_result` into the result register (address 2). It also sets `done_flag` and status bit 7. A read of address 2 with `rd_en` clears them.
- R7: Each completed conversion advances the list pointer by one and wraps from the entry at the stored length back to entry 0. `chan_sel` and `gain_sel` show the entry that the next conversion will use.
- R8: A `pacer_tick` starts a conversion only while the clock-enable bit (status bit 9, written through address 0) is set.
- R9: If a trigger is accepted while `done_flag` is set, `err_flag` and status bit 15 rise. They stay set until an init command.
- R10: A supervisor write with bit 6 set clears done, error, busy, the settled state and the list pointer. The stored list entries are kept.
- R11: A supervisor write with bit 0 set clears everything, including the list entries, the length field and the control bits.
- R12: With a length code of 0, every conversion uses entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register address |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe (side effect only for address 2) |
| rd_addr | input | 2 | Read register address |
| rd_data | output | 16 | Read data for rd_addr |
| pacer_tick | input | 1 | Periodic conversion request |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_done | input | 1 | Conversion-complete strobe from the converter |
| conv_result | input | RES_W | Converter result, valid with conv_done |
| chan_sel | output | 4 | Multiplexer channel of the current entry |
| gain_sel | output | 2 | Gain code of the current entry |
| done_flag | output | 1 | Unread result present |
| err_flag | output | 1 | Sticky overrun error |

## Verification
The bound checker watches five things on every cycle:
- `conv_start` is a single-cycle pulse.
- No start follows a busy cycle.
- A pacer tick without the enable bit starts nothing.
- The error flag holds until an init.
- Each completion sets the done flag and moves the pointer with the correct wrap.

Some behaviours only the bench scenarios can show. These are the exact settle length, the list contents produced by load mode, the channel order across a full 16-entry list and a single-entry list, what an init keeps and what it drops, and the value carried from `conv_result` to the result register.

// File: rtl/cg_scan_pkg.sv
package cg_scan_pkg;
  localparam int CH_W    = 4;
  localparam int GAIN_W  = 2;
  localparam int IDX_W   = 4;
  localparam int DEPTH   = 1 << IDX_W;
  localparam int REG_W   = 16;

  localparam logic [1:0] A_ADCTL = 2'd0;
  localparam logic [1:0] A_LIST  = 2'd1;
  localparam logic [1:0] A_DATA  = 2'd2;
  localparam logic [1:0] A_SUP   = 2'd3;

  localparam int B_LOAD_EN  = 15;
  localparam int B_ERR      = 15;
  localparam int B_CLK_EN   = 9;
  localparam int B_BUSY     = 8;
  localparam int B_DONE     = 7;
  localparam int B_DONE_IE  = 6;
  localparam int B_GAIN_LO  = 4;
  localparam int B_CMD_ADI  = 6;
  localparam int B_CMD_PRE  = 4;
  localparam int B_CMD_TRG  = 3;
  localparam int B_CMD_BDI  = 0;

  typedef struct packed {
    logic [GAIN_W-1:0] gain;
    logic [CH_W-1:0]   chan;
  } cg_entry_t;

  function automatic logic [IDX_W-1:0] wrap_next(input logic [IDX_W-1:0] cur,
                                                 input logic [IDX_W-1:0] last);
    return (cur == last) ? '0 : cur + 1'b1;
  endfunction

  function automatic logic [REG_W-1:0] pack_status(input logic err, input logic clk_en,
                                                   input logic busy, input logic done,
                                                   input logic ie, input cg_entry_t cur);
    logic [REG_W-1:0] s;
    s = '0;
    s[B_ERR]     = err;
    s[B_CLK_EN]  = clk_en;
    s[B_BUSY]    = busy;
    s[B_DONE]    = done;
    s[B_DONE_IE] = ie;
    s[B_GAIN_LO +: GAIN_W] = cur.gain;
    s[CH_W-1:0]  = cur.chan;
    return s;
  endfunction
endpackage

// File: rtl/cg_list_store.sv
module cg_list_store
  import cg_scan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ptr_rst,
  input  logic             wr_en,
  input  cg_entry_t        wr_entry,
  input  logic [IDX_W-1:0] rd_idx,
  output cg_entry_t        rd_entry
);
  logic [IDX_W-1:0] wptr;
  cg_entry_t        ents [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 wptr <= '0;
    else if (clr || ptr_rst)    wptr <= '0;
    else if (wr_en)             wptr <= wptr + 1'b1;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                ents[g] <= '0;
      else if (clr)                              ents[g] <= '0;
      else if (wr_en && wptr == IDX_W'(g))       ents[g] <= wr_entry;
    end
  end

  assign rd_entry = ents[rd_idx];
endmodule

// File: rtl/cg_settle_timer.sv
module cg_settle_timer #(
  parameter int SETTLE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic start,
  output logic busy,
  output logic armed
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; armed <= 1'b0; cnt <= '0;
    end else if (clr) begin
      busy <= 1'b0; armed <= 1'b0; cnt <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      armed <= 1'b0;
      cnt   <= CNT_W'(SETTLE_CYC - 1);
    end else if (busy) begin
      if (cnt == '0) begin
        busy  <= 1'b0;
        armed <= 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/cg_conv_ctrl.sv
module cg_conv_ctrl
  import cg_scan_pkg::*;
#(
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ptr_rst,
  input  logic             trig_req,
  input  logic             armed,
  input  logic             busy,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result,
  input  logic             data_rd,
  input  logic [IDX_W-1:0] last_idx,
  output logic             trig_accept,
  output logic             conv_start,
  output logic             in_flight,
  output logic             done,
  output logic             err,
  output logic [IDX_W-1:0] rptr,
  output logic [RES_W-1:0] result_q
);
  logic complete;

  assign trig_accept = trig_req && armed && !busy && !in_flight && !clr;
  assign complete    = conv_done && in_flight;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_start <= 1'b0; in_flight <= 1'b0; done <= 1'b0;
      err <= 1'b0; rptr <= '0; result_q <= '0;
    end else if (clr) begin
      conv_start <= 1'b0; in_flight <= 1'b0; done <= 1'b0;
      err <= 1'b0; rptr <= '0;
    end else begin
      conv_start <= trig_accept;
      if (trig_accept) begin
        in_flight <= 1'b1;
        if (done) err <= 1'b1;
      end else if (complete) begin
        in_flight <= 1'b0;
      end
      if (complete) begin
        done     <= 1'b1;
        result_q <= conv_result;
      end else if (data_rd) begin
        done <= 1'b0;
      end
      if (ptr_rst)       rptr <= '0;
      else if (complete) rptr <= wrap_next(rptr, last_idx);
    end
  end
endmodule

// File: rtl/cg_scan_seq.sv
module cg_scan_seq
  import cg_scan_pkg::*;
#(
  parameter int SETTLE_CYC = 4,
  parameter int RES_W      = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           wr_addr,
  input  logic [15:0]          wr_data,
  input  logic                 rd_en,
  input  logic [1:0]           rd_addr,
  output logic [15:0]          rd_data,
  input  logic                 pacer_tick,
  output logic                 conv_start,
  input  logic                 conv_done,
  input  logic [RES_W-1:0]     conv_result,
  output logic [CH_W-1:0]      chan_sel,
  output logic [GAIN_W-1:0]    gain_sel,
  output logic                 done_flag,
  output logic                 err_flag
);
  logic wr_sup, wr_list, wr_adctl;
  logic board_init, adc_init, conv_clr, preload_cmd, sw_trig_cmd;
  logic load_en, clk_en, done_ie;
  logic [IDX_W-1:0] last_idx, rptr;
  logic trig_req, trig_accept, mux_busy, armed, in_flight, data_rd;
  logic [RES_W-1:0] result_q;
  cg_entry_t cur_entry, new_entry;
  logic unused_bits;

  assign wr_sup      = wr_en && wr_addr == A_SUP;
  assign wr_list     = wr_en && wr_addr == A_LIST;
  assign wr_adctl    = wr_en && wr_addr == A_ADCTL;
  assign board_init  = wr_sup && wr_data[B_CMD_BDI];
  assign adc_init    = wr_sup && wr_data[B_CMD_ADI];
  assign conv_clr    = board_init || adc_init;
  assign preload_cmd = wr_sup && wr_data[B_CMD_PRE] && !conv_clr;
  assign sw_trig_cmd = wr_sup && wr_data[B_CMD_TRG];
  assign trig_req    = sw_trig_cmd || (clk_en && pacer_tick);
  assign data_rd     = rd_en && rd_addr == A_DATA;
  assign new_entry   = '{gain: wr_data[B_GAIN_LO +: GAIN_W], chan: wr_data[CH_W-1:0]};
  assign unused_bits = ^{wr_data[14:10], wr_data[8:7]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_en <= 1'b0; last_idx <= '0; clk_en <= 1'b0; done_ie <= 1'b0;
    end else if (board_init) begin
      load_en <= 1'b0; last_idx <= '0; clk_en <= 1'b0; done_ie <= 1'b0;
    end else begin
      if (wr_list) begin
        load_en  <= wr_data[B_LOAD_EN];
        last_idx <= wr_data[IDX_W-1:0];
      end
      if (wr_adctl) begin
        clk_en  <= wr_data[B_CLK_EN];
        done_ie <= wr_data[B_DONE_IE];
      end
    end
  end

  cg_list_store u_store (
    .clk(clk), .rst_n(rst_n), .clr(board_init), .ptr_rst(wr_list),
    .wr_en(wr_adctl && load_en), .wr_entry(new_entry),
    .rd_idx(rptr), .rd_entry(cur_entry)
  );

  cg_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n), .clr(conv_clr), .start(preload_cmd),
    .busy(mux_busy), .armed(armed)
  );

  cg_conv_ctrl #(.RES_W(RES_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clr(conv_clr), .ptr_rst(preload_cmd),
    .trig_req(trig_req), .armed(armed), .busy(mux_busy),
    .conv_done(conv_done), .conv_result(conv_result), .data_rd(data_rd),
    .last_idx(last_idx), .trig_accept(trig_accept), .conv_start(conv_start),
    .in_flight(in_flight), .done(done_flag), .err(err_flag),
    .rptr(rptr), .result_q(result_q)
  );

  assign chan_sel = cur_entry.chan;
  assign gain_sel = cur_entry.gain;

  always_comb begin
    unique case (rd_addr)
      A_ADCTL: rd_data = pack_status(err_flag, clk_en, mux_busy, done_flag, done_ie, cur_entry);
      A_LIST:  rd_data = {load_en, {(REG_W-1-IDX_W){1'b0}}, last_idx};
      A_DATA:  rd_data = 16'(result_q);
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/cg_scan_seq_chk.sv
module cg_scan_seq_chk
  import cg_scan_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             conv_start,
  input logic             conv_done,
  input logic             mux_busy,
  input logic             in_flight,
  input logic             done_flag,
  input logic             err_flag,
  input logic             conv_clr,
  input logic             preload_cmd,
  input logic             pacer_tick,
  input logic             clk_en,
  input logic             sw_trig_cmd,
  input logic [IDX_W-1:0] rptr,
  input logic [IDX_W-1:0] last_idx
);
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start); // R5
  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mux_busy |=> !conv_start); // R4
  AST_PACER_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (pacer_tick && !clk_en && !sw_trig_cmd) |=> !conv_start); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !conv_clr) |=> err_flag); // R9
  AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && in_flight && !conv_clr) |=> done_flag); // R6
  AST_BUSY_PRELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    preload_cmd |=> mux_busy); // R3
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && in_flight && !conv_clr && !preload_cmd) |=>
      rptr == (($past(rptr) == $past(last_idx)) ? '0 : $past(rptr) + 1'b1)); // R7
endmodule

bind cg_scan_seq cg_scan_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_done(conv_done),
  .mux_busy(mux_busy), .in_flight(in_flight), .done_flag(done_flag),
  .err_flag(err_flag), .conv_clr(conv_clr), .preload_cmd(preload_cmd),
  .pacer_tick(pacer_tick), .clk_en(clk_en), .sw_trig_cmd(sw_trig_cmd),
  .rptr(rptr), .last_idx(last_idx)
);

// File: tb/cg_scan_seq_bench.sv
module cg_scan_seq_bench;
  localparam int SETTLE = 4;
  localparam int LAT    = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, pacer_tick = 1'b0, conv_done = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0, rd_data, conv_result = '0;
  logic conv_start, done_flag, err_flag;
  logic [3:0] chan_sel;
  logic [1:0] gain_sel;

  int n_chk = 0, n_fail = 0, conv_cnt = 0, seq = 0;
  bit finished = 0;
  logic [5:0]  exp_q[$];
  logic [15:0] data_q[$];

  always #2 clk = ~clk;

  cg_scan_seq #(.SETTLE_CYC(SETTLE), .RES_W(16)) u_cg_scan_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .pacer_tick(pacer_tick),
    .conv_start(conv_start), .conv_done(conv_done), .conv_result(conv_result),
    .chan_sel(chan_sel), .gain_sel(gain_sel), .done_flag(done_flag), .err_flag(err_flag)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] d);
    rd_addr = a; #1 d = rd_data;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 60 && !done_flag; i++) @(negedge clk);
  endtask

  // pops the scoreboard's data queue and compares with the result register
  task automatic read_result(input string req);
    logic [15:0] d, e;
    @(negedge clk); rd_addr = 2'd2; rd_en = 1'b1; #1 d = rd_data;
    @(negedge clk); rd_en = 1'b0;
    e = (data_q.size() > 0) ? data_q.pop_front() : 16'hDEAD;
    chk(d == e, req, d, e);
    chk(!done_flag, "R6 done cleared by read", done_flag, 0);
  endtask

  task automatic convert_sw(input logic [3:0] ch, input logic [1:0] g);
    exp_q.push_back({g, ch});
    wr(2'd3, 16'h0008);
    wait_done();
    chk(done_flag, "R6 done set", done_flag, 1);
    read_result("R6 result");
  endtask

  task automatic preload_settle();
    wr(2'd3, 16'h0010);
    repeat (SETTLE + 2) @(negedge clk);
  endtask

  // converter model and scoreboard monitor
  initial begin
    logic [5:0] e;
    logic [15:0] res;
    forever begin
      @(negedge clk);
      if (conv_start) begin
        conv_cnt++;
        if (exp_q.size() == 0) chk(0, "R4 unexpected conversion", {gain_sel, chan_sel}, 0);
        else begin
          e = exp_q.pop_front();
          chk({gain_sel, chan_sel} == e, "R7 entry order", {gain_sel, chan_sel}, e);
        end
        res = {4'hA, 6'(seq), gain_sel, chan_sel};
        seq++;
        data_q.push_back(res);
        repeat (LAT - 1) @(negedge clk);
        conv_done = 1'b1; conv_result = res;
        @(negedge clk); conv_done = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] s;
    int c0, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    peek(2'd0, s);
    chk(s == 16'h0000, "R1 status", s, 0);
    chk(chan_sel == 0 && gain_sel == 0, "R1 sel", {gain_sel, chan_sel}, 0);
    chk(!done_flag && !err_flag && !conv_start, "R1 flags", {done_flag, err_flag, conv_start}, 0);

    // R2: load three entries
    wr(2'd1, 16'h8002);
    wr(2'd0, 16'h0015);
    wr(2'd0, 16'h0029);
    wr(2'd0, 16'h003F);
    wr(2'd1, 16'h0002);
    peek(2'd1, s);
    chk(s == 16'h0002, "R2 length readback", s, 16'h0002);
    chk(chan_sel == 5 && gain_sel == 1, "R2 entry0", {gain_sel, chan_sel}, 6'h15);

    // R4: trigger before preload
    c0 = conv_cnt;
    wr(2'd3, 16'h0008);
    repeat (6) @(negedge clk);
    chk(conv_cnt == c0, "R4 not preloaded", conv_cnt, c0);

    // R3: busy length
    wr(2'd3, 16'h0010);
    peek(2'd0, s);
    n = 0;
    while (s[8] && n < 100) begin n++; @(negedge clk); peek(2'd0, s); end
    chk(n == SETTLE, "R3 busy cycles", n, SETTLE);

    // R4: trigger while busy
    c0 = conv_cnt;
    wr(2'd3, 16'h0010);
    wr(2'd3, 16'h0008);
    repeat (SETTLE + 4) @(negedge clk);
    chk(conv_cnt == c0, "R4 busy trigger", conv_cnt, c0);

    // R5: start pulse timing
    exp_q.push_back(6'h15);
    wr(2'd3, 16'h0008);
    chk(conv_start == 1'b1, "R5 start high", conv_start, 1);
    @(negedge clk);
    chk(conv_start == 1'b0, "R5 start one cycle", conv_start, 0);
    wait_done();
    peek(2'd0, s);
    chk(s[7] == 1'b1, "R6 status done bit", s[7], 1);
    read_result("R6 result");

    // R7: walk and wrap
    convert_sw(4'd9, 2'd2);
    convert_sw(4'd15, 2'd3);
    convert_sw(4'd5, 2'd1);

    // R8: pacer gating
    c0 = conv_cnt;
    @(negedge clk); pacer_tick = 1'b1; @(negedge clk); pacer_tick = 1'b0;
    repeat (6) @(negedge clk);
    chk(conv_cnt == c0, "R8 pacer gated", conv_cnt, c0);
    wr(2'd0, 16'h0200);
    peek(2'd0, s);
    chk(s[9] == 1'b1, "R8 enable readback", s[9], 1);
    exp_q.push_back(6'h29);
    @(negedge clk); pacer_tick = 1'b1; @(negedge clk); pacer_tick = 1'b0;
    wait_done();
    chk(conv_cnt == c0 + 1, "R8 pacer conversion", conv_cnt, c0 + 1);
    read_result("R8 result");
    wr(2'd0, 16'h0000);

    // R9: overrun
    exp_q.push_back(6'h3F);
    wr(2'd3, 16'h0008);
    wait_done();
    chk(!err_flag, "R9 no error yet", err_flag, 0);
    exp_q.push_back(6'h15);
    wr(2'd3, 16'h0008);
    chk(err_flag, "R9 error set", err_flag, 1);
    wait_done();
    repeat (LAT + 2) @(negedge clk);
    void'(data_q.pop_front());
    read_result("R9 result after overrun");
    peek(2'd0, s);
    chk(s[15] && err_flag, "R9 error sticky", {s[15], err_flag}, 2'b11);

    // R10: conversion init keeps the list
    wr(2'd3, 16'h0040);
    peek(2'd0, s);
    chk(!err_flag && !done_flag && !s[8], "R10 flags cleared", {err_flag, done_flag, s[8]}, 0);
    chk(chan_sel == 5 && gain_sel == 1, "R10 pointer to entry0", {gain_sel, chan_sel}, 6'h15);
    c0 = conv_cnt;
    wr(2'd3, 16'h0008);
    repeat (6) @(negedge clk);
    chk(conv_cnt == c0, "R10 not armed after init", conv_cnt, c0);

    // R7: full 16-entry list with wrap
    wr(2'd1, 16'h800F);
    for (int i = 0; i < 16; i++) wr(2'd0, 16'({2'(i % 4), 4'(i)}));
    wr(2'd1, 16'h000F);
    preload_settle();
    for (int k = 0; k < 17; k++) convert_sw(4'(k % 16), 2'((k % 16) % 4));
    chk(chan_sel == 1 && gain_sel == 1, "R7 after wrap", {gain_sel, chan_sel}, 6'h11);

    // R12: single entry
    wr(2'd1, 16'h8000);
    wr(2'd0, 16'h0027);
    wr(2'd1, 16'h0000);
    preload_settle();
    convert_sw(4'd7, 2'd2);
    convert_sw(4'd7, 2'd2);
    chk(chan_sel == 7 && gain_sel == 2, "R12 stays on entry0", {gain_sel, chan_sel}, 6'h27);

    // R11: board init
    wr(2'd0, 16'h0240);
    wr(2'd3, 16'h0001);
    peek(2'd1, s);
    chk(s == 16'h0000, "R11 list ctl cleared", s, 0);
    peek(2'd0, s);
    chk(s == 16'h0000, "R11 status cleared", s, 0);
    chk(chan_sel == 0 && gain_sel == 0, "R11 list entries cleared", {gain_sel, chan_sel}, 0);

    chk(exp_q.size() == 0, "R4 pending expectations", exp_q.size(), 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule